// File: doc/BRIEF.md
# Time-Division-Multiplexed ISDN Line-Card Bus Transceiver

This block connects a line card's parallel registers to a four-wire serial bus that carries basic-rate ISDN traffic. The four wires are a frame pulse, a data clock, a receive line and a transmit line. A frame holds `NUM_SLOTS` channel slots placed back to back. Each slot carries two 8-bit bearer fields, an 8-bit monitor field, a 2-bit signalling field, a 4-bit command/indicate field, and two single control bits. The data clock runs at twice the bit rate, so every bit lasts two data-clock periods.

A configuration input names the one slot this transceiver owns. During that slot the block shifts out the transmit fields it captured at the last frame pulse, and it assembles the incoming bits into receive registers. It releases the transmit line in every other slot. It tracks its position within the frame by counting data-clock edges. When a frame pulse arrives at an unexpected position, it realigns to that pulse and reports the event.

All bus inputs are assumed to be synchronous to `clk`, which must run at least four times faster than the data clock. Data-clock edges are found inside the `clk` domain.

Top module: `gci_tdm_xcvr`

## Requirements
- R1: After reset, `serOut` is 1, `serOutEn`, `rxDone` and `syncErr` are 0, and all receive field outputs are 0.
- R2: A bit period covers two rising data-clock edges. The transmitter changes `serOut` only on the first edge of the period and holds it through the second. The receiver samples `serIn` only on the second edge.
- R3: A frame is `NUM_SLOTS`×32 bits long. A frame pulse seen high at a rising data-clock edge marks that edge as the first edge of bit 0 of slot 0. Slot s occupies bits 32·s to 32·s+31.
- R4: Within a slot the 32-bit word is sent most significant bit first and is laid out as B1 in [31:24], B2 in [23:16], monitor in [15:8], D in [7:6], command/indicate in [5:2], A in [1] and E in [0].
- R5: `serOutEn` is 1 only during the slot selected by `ownSlot`. At all other times, including before the first frame pulse after reset, `serOutEn` is 0 and `serOut` is 1.
- R6: When the last bit of the owned slot has been sampled, the receive outputs are loaded with that slot's word, using the layout of R4, and `rxDone` pulses high for one `clk` cycle.
- R7: The transmit field inputs are captured at the frame pulse. A change to them during a frame affects only the next frame.
- R8: A frame pulse that arrives at any position other than the end of the previous frame produces a one-cycle `syncErr` pulse, and counting restarts from that pulse. The first pulse after reset and pulses that arrive on time produce no error.
- R9: `serIn` activity outside the owned slot has no effect on the receive outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame pulse, sampled at data-clock rising edges |
| dataClk | input | 1 | Bus data clock (two periods per bit) |
| serIn | input | 1 | Serial receive data |
| ownSlot | input | SLOT_W | Index of the slot this transceiver owns |
| txB1 | input | 8 | Transmit bearer field 1 |
| txB2 | input | 8 | Transmit bearer field 2 |
| txMon | input | 8 | Transmit monitor field |
| txD | input | 2 | Transmit signalling field |
| txCi | input | 4 | Transmit command/indicate field |
| txA | input | 1 | Transmit A bit |
| txE | input | 1 | Transmit E bit |
| serOut | output | 1 | Serial transmit data (1 when released) |
| serOutEn | output | 1 | Transmit line drive enable |
| rxB1 | output | 8 | Received bearer field 1 |
| rxB2 | output | 8 | Received bearer field 2 |
| rxMon | output | 8 | Received monitor field |
| rxD | output | 2 | Received signalling field |
| rxCi | output | 4 | Received command/indicate field |
| rxA | output | 1 | Received A bit |
| rxE | output | 1 | Received E bit |
| rxDone | output | 1 | One-cycle strobe when the owned slot has been captured |
| syncErr | output | 1 | One-cycle strobe on a misplaced frame pulse |

## Verification
The hardest conditions to reach from the ports are frame pulses that arrive at the wrong position. The bench produces an early pulse by stopping a frame after 100 half-bits and sending a new pulse. It produces a late pulse by running 20 half-bits past the frame end, so the counter wraps without a pulse before the next one arrives. In both cases it then confirms that one error is reported and that the following frame is clean. Two other conditions also need deliberate stimulus. Mid-bit sampling is exposed by driving the inverse of each receive bit during the first half of its period. Capture at the frame pulse is exposed by rewriting the transmit fields partway through a frame.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int B_W       = 8;
  localparam int MON_W     = 8;
  localparam int D_W       = 2;
  localparam int CI_W      = 4;
  localparam int SLOT_BITS = 2 * B_W + MON_W + D_W + CI_W + 2;
  localparam int BIT_IDX_W = $clog2(SLOT_BITS);

  typedef struct packed {
    logic                 dclkEdge;
    logic                 syncHit;
    logic                 inSlot;
    logic                 driveBit;
    logic                 sampleBit;
    logic                 slotEnd;
    logic [BIT_IDX_W-1:0] bitIdx;
  } gciStrobe_t;
endpackage

// File: rtl/gci_frame_ctrl.sv
module gci_frame_ctrl
  import gci_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int POS_W     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataClk,
  input  logic              frameSync,
  input  logic [SLOT_W-1:0] ownSlot,
  output gciStrobe_t        strb,
  output logic              syncErr
);
  localparam int HALF_PER_SLOT = SLOT_BITS * 2;
  localparam int POS_LAST      = NUM_SLOTS * HALF_PER_SLOT - 1;

  logic              dclkQ;
  logic              aligned;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  nextPos;
  logic              rise;
  logic              syncNow;
  logic              live;
  logic [SLOT_W-1:0] curSlot;

  always_comb begin
    rise    = dataClk & ~dclkQ;
    syncNow = rise & frameSync;
    if (syncNow || pos == POS_W'(POS_LAST)) nextPos = '0;
    else                                    nextPos = pos + 1'b1;
    curSlot = SLOT_W'(nextPos / POS_W'(HALF_PER_SLOT));
    live    = aligned | syncNow;

    strb.dclkEdge  = rise;
    strb.syncHit   = syncNow;
    strb.inSlot    = live && (curSlot == ownSlot);
    strb.driveBit  = rise && strb.inSlot && !nextPos[0];
    strb.sampleBit = rise && strb.inSlot && nextPos[0];
    strb.bitIdx    = nextPos[BIT_IDX_W:1];
    strb.slotEnd   = strb.sampleBit && (strb.bitIdx == BIT_IDX_W'(SLOT_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dclkQ   <= 1'b0;
      aligned <= 1'b0;
      pos     <= '0;
      syncErr <= 1'b0;
    end else begin
      dclkQ   <= dataClk;
      syncErr <= syncNow && aligned && (pos != POS_W'(POS_LAST));
      if (rise)    pos     <= nextPos;
      if (syncNow) aligned <= 1'b1;
    end
  end

  // R3: the position counter never leaves the frame
  assert_pos_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    pos <= POS_W'(POS_LAST));

  // R8: an error report always follows a frame pulse at a data-clock rise
  assert_err_at_sync_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |-> $past(frameSync && dataClk));
endmodule

// File: rtl/gci_field_path.sv
module gci_field_path
  import gci_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  gciStrobe_t       strb,
  input  logic             serIn,
  input  logic [B_W-1:0]   txB1,
  input  logic [B_W-1:0]   txB2,
  input  logic [MON_W-1:0] txMon,
  input  logic [D_W-1:0]   txD,
  input  logic [CI_W-1:0]  txCi,
  input  logic             txA,
  input  logic             txE,
  output logic             serOut,
  output logic             serOutEn,
  output logic [B_W-1:0]   rxB1,
  output logic [B_W-1:0]   rxB2,
  output logic [MON_W-1:0] rxMon,
  output logic [D_W-1:0]   rxD,
  output logic [CI_W-1:0]  rxCi,
  output logic             rxA,
  output logic             rxE,
  output logic             rxDone
);
  localparam int TOP = SLOT_BITS - 1;

  logic [SLOT_BITS-1:0] txWord;
  logic [SLOT_BITS-1:0] shadow;
  logic [SLOT_BITS-1:0] src;
  logic [SLOT_BITS-1:0] rxShift;
  logic [SLOT_BITS-1:0] rxWord;

  always_comb begin
    txWord = {txB1, txB2, txMon, txD, txCi, txA, txE};
    src    = strb.syncHit ? txWord : shadow;
    rxWord = {rxShift[SLOT_BITS-2:0], serIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow   <= '0;
      serOut   <= 1'b1;
      serOutEn <= 1'b0;
      rxShift  <= '0;
      rxDone   <= 1'b0;
      {rxB1, rxB2, rxMon, rxD, rxCi, rxA, rxE} <= '0;
    end else begin
      rxDone <= strb.slotEnd;
      if (strb.syncHit) shadow <= txWord;
      if (strb.dclkEdge) begin
        serOutEn <= strb.inSlot;
        if (strb.driveBit)    serOut <= src[BIT_IDX_W'(TOP) - strb.bitIdx];
        else if (!strb.inSlot) serOut <= 1'b1;
      end
      if (strb.sampleBit) rxShift <= rxWord;
      if (strb.slotEnd) {rxB1, rxB2, rxMon, rxD, rxCi, rxA, rxE} <= rxWord;
    end
  end

  // R5: a released line always idles high
  assert_release_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    !serOutEn |-> serOut);

  // R2: while driving, the line only moves on a drive strobe
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (serOutEn && !strb.driveBit) |=> ($stable(serOut) || !serOutEn));

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);
endmodule

// File: rtl/gci_tdm_xcvr.sv
module gci_tdm_xcvr
  import gci_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int POS_W    = $clog2(NUM_SLOTS * SLOT_BITS * 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              dataClk,
  input  logic              serIn,
  input  logic [SLOT_W-1:0] ownSlot,
  input  logic [7:0]        txB1,
  input  logic [7:0]        txB2,
  input  logic [7:0]        txMon,
  input  logic [1:0]        txD,
  input  logic [3:0]        txCi,
  input  logic              txA,
  input  logic              txE,
  output logic              serOut,
  output logic              serOutEn,
  output logic [7:0]        rxB1,
  output logic [7:0]        rxB2,
  output logic [7:0]        rxMon,
  output logic [1:0]        rxD,
  output logic [3:0]        rxCi,
  output logic              rxA,
  output logic              rxE,
  output logic              rxDone,
  output logic              syncErr
);
  gciStrobe_t strb;

  gci_frame_ctrl #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .POS_W    (POS_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .dataClk  (dataClk),
    .frameSync(frameSync),
    .ownSlot  (ownSlot),
    .strb     (strb),
    .syncErr  (syncErr)
  );

  gci_field_path uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .serIn   (serIn),
    .txB1    (txB1),
    .txB2    (txB2),
    .txMon   (txMon),
    .txD     (txD),
    .txCi    (txCi),
    .txA     (txA),
    .txE     (txE),
    .serOut  (serOut),
    .serOutEn(serOutEn),
    .rxB1    (rxB1),
    .rxB2    (rxB2),
    .rxMon   (rxMon),
    .rxD     (rxD),
    .rxCi    (rxCi),
    .rxA     (rxA),
    .rxE     (rxE),
    .rxDone  (rxDone)
  );
endmodule

// File: tb/tb_gci_tdm_xcvr.sv
module tb_gci_tdm_xcvr;
  localparam int NSLOT = 8;
  localparam int HALVES = NSLOT * 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0, dataClk = 1'b0, serIn = 1'b0;
  logic [2:0] ownSlot = 3'd3;
  logic [7:0] txB1 = '0, txB2 = '0, txMon = '0;
  logic [1:0] txD = '0;
  logic [3:0] txCi = '0;
  logic txA = 1'b0, txE = 1'b0;
  logic serOut, serOutEn, rxA, rxE, rxDone, syncErr;
  logic [7:0] rxB1, rxB2, rxMon;
  logic [1:0] rxD;
  logic [3:0] rxCi;

  int checkCount = 0, passCount = 0, errSeen = 0;
  bit midBit = 0, expIn = 0, benchAligned = 0;
  string txTag = "R4";
  logic txQ[$];
  logic [31:0] rxQ[$];

  always #2.5 clk = ~clk;

  gci_tdm_xcvr dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .dataClk(dataClk), .serIn(serIn),
    .ownSlot(ownSlot), .txB1(txB1), .txB2(txB2), .txMon(txMon), .txD(txD), .txCi(txCi),
    .txA(txA), .txE(txE), .serOut(serOut), .serOutEn(serOutEn), .rxB1(rxB1), .rxB2(rxB2),
    .rxMon(rxMon), .rxD(rxD), .rxCi(rxCi), .rxA(rxA), .rxE(rxE), .rxDone(rxDone),
    .syncErr(syncErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (ok) passCount++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic setTx(input logic [31:0] w);
    {txB1, txB2, txMon, txD, txCi, txA, txE} = w;
  endtask

  // monitor: pops expected items as results appear
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (midBit) begin
        if (expIn) begin
          logic e;
          e = (txQ.size() > 0) ? txQ.pop_front() : 1'bx;
          chk(serOutEn === 1'b1 && serOut === e, txTag, "tx bit", {serOutEn, serOut}, {1'b1, e});
        end else begin
          chk(serOutEn === 1'b0 && serOut === 1'b1, "R5", "released line", {serOutEn, serOut}, 2'b01);
        end
      end
      if (rxDone) begin
        logic [31:0] got, want;
        got = {rxB1, rxB2, rxMon, rxD, rxCi, rxA, rxE};
        want = (rxQ.size() > 0) ? rxQ.pop_front() : 32'hxxxxxxxx;
        chk(got === want, "R6 R9", "rx fields", got, want);
      end
      if (syncErr) errSeen++;
    end
  end

  task automatic runFrame(input bit doSync, input int halves, input logic [31:0] txNow,
                          input logic [31:0] rxW, input int midAt, input logic [31:0] txLater);
    int slotStart;
    bit live;
    slotStart = int'(ownSlot) * 64;
    live = benchAligned || doSync;
    setTx(txNow);
    if (doSync && halves >= slotStart + 64) begin
      for (int i = 31; i >= 0; i--) txQ.push_back(txNow[i]);
      rxQ.push_back(rxW);
    end
    for (int h = 0; h < halves; h++) begin
      int hm, bi;
      bit own;
      @(negedge clk);
      if (h == midAt) setTx(txLater);
      hm = h % HALVES;
      bi = (hm % 64) / 2;
      own = live && (hm / 64 == int'(ownSlot));
      dataClk = 1'b1;
      frameSync = doSync && (h == 0);
      // R2: wrong value in the first half, correct value at mid-bit
      if (own) serIn = (h % 2 == 1) ? rxW[31-bi] : ~rxW[31-bi];
      else     serIn = h[0] ^ h[3];
      midBit = (h % 2 == 1);
      expIn = own;
      @(negedge clk);
      frameSync = 1'b0;
      midBit = 1'b0;
      @(negedge clk);
      dataClk = 1'b0;
      @(negedge clk);
    end
    if (doSync) benchAligned = 1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", passCount, checkCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(serOut === 1'b1 && serOutEn === 1'b0, "R1", "line after reset", {serOutEn, serOut}, 2'b01);
    chk(rxDone === 1'b0 && syncErr === 1'b0, "R1", "strobes after reset", {rxDone, syncErr}, 2'b00);
    chk({rxB1, rxB2, rxMon, rxD, rxCi, rxA, rxE} === 32'd0, "R1", "rx fields after reset",
        {rxB1, rxB2, rxMon, rxD, rxCi, rxA, rxE}, 32'd0);

    // R5: clocks without any frame pulse keep the line released
    runFrame(1'b0, 40, 32'hFFFF_FFFF, 32'h0, -1, 32'h0);
    chk(errSeen == 0, "R8", "no error before first pulse", errSeen, 0);

    // R3 R4 R6: first aligned frame, slot 3
    txTag = "R4";
    runFrame(1'b1, HALVES, 32'hA5C3_5A96, 32'h1234_ABCD, -1, 32'h0);
    chk(errSeen == 0, "R8", "first pulse is not an error", errSeen, 0);

    // R7: fields rewritten mid-frame, before the owned slot
    txTag = "R7";
    runFrame(1'b1, HALVES, 32'h0F0F_33CC, 32'hFEDC_0123, 60, 32'h6B2D_E781);
    runFrame(1'b1, HALVES, 32'h6B2D_E781, 32'h8000_0001, -1, 32'h0);
    chk(errSeen == 0, "R3", "on-time pulses give no error", errSeen, 0);

    // R3 boundary slots
    txTag = "R4";
    ownSlot = 3'd0;
    runFrame(1'b1, HALVES, 32'hC001_D00D, 32'h5555_AAAA, -1, 32'h0);
    ownSlot = 3'd7;
    runFrame(1'b1, HALVES, 32'h7E81_18E7, 32'hDEAD_BEEF, -1, 32'h0);
    chk(errSeen == 0, "R3", "last slot ends frame cleanly", errSeen, 0);

    // R8 early pulse
    ownSlot = 3'd3;
    runFrame(1'b1, 100, 32'h0, 32'h0, -1, 32'h0);
    runFrame(1'b1, HALVES, 32'h2468_ACE0, 32'h1357_9BDF, -1, 32'h0);
    chk(errSeen == 1, "R8", "early pulse flagged", errSeen, 1);

    // R8 late pulse: counter wraps before the next pulse
    runFrame(1'b1, HALVES + 20, 32'h9999_6666, 32'h0FF0_F00F, -1, 32'h0);
    runFrame(1'b1, HALVES, 32'h3C3C_C3C3, 32'hB00B_1E55, -1, 32'h0);
    chk(errSeen == 2, "R8", "late pulse flagged", errSeen, 2);
    runFrame(1'b1, HALVES, 32'h0000_0001, 32'hFFFF_FFFE, -1, 32'h0);
    chk(errSeen == 2, "R8", "realigned frame clean", errSeen, 2);

    repeat (8) @(negedge clk);
    chk(txQ.size() == 0, "R4", "all tx bits seen", txQ.size(), 0);
    chk(rxQ.size() == 0, "R6", "all rx slots completed", rxQ.size(), 0);
    finishRun();
  end
endmodule